// File: doc/BRIEF.md
# Multiplexed CAM Bus Master

This block performs one byte-wide access to a common-interface module that sits behind an 8-bit multiplexed bus. The address and the data share the same eight lines. The block first presents the low address byte with a low-address latch strobe. It then presents the high address byte with a high-address latch strobe. Next it drives the write byte, or releases the lines for a read. It pulls one of two active-low chip selects low according to the target. Finally it asserts the active-low read or write strobe and waits for the module's active-low acknowledge. If no acknowledge arrives within a parameterized number of clock cycles, the wait ends with a timeout flag.

The host presents a one-cycle `req` with a slot index, a 16-bit address, a write byte, a read/write bit, a space bit (attribute memory or control space) and a target bit. The block answers with a one-cycle `ready` that carries the read byte, a timeout flag and a reject flag. The space bit must be mirrored into a 2-bit field of the interface chip's configuration. The block therefore emits a one-cycle configuration-update strobe, but only when the requested space differs from the one used last.

The state machine has seven states. IDLE accepts a request. SPACE issues the configuration update. ADDR_LO and ADDR_HI are the two address latch phases. DATA sets the direction of the data lines. SELECT drops the chip select. STROBE holds the access strobe and waits for the acknowledge. The transitions are as follows. IDLE goes to SPACE when the space changes, or to ADDR_LO otherwise. A request with a nonzero slot leaves the block in IDLE. SPACE goes to ADDR_LO. ADDR_LO and ADDR_HI each advance after SETUP_CYC+1 cycles. DATA and SELECT each advance after SETUP_CYC cycles. STROBE returns to IDLE on a synchronized acknowledge or when the timeout expires.

Top module: `cam_bus_master`

## Requirements
- R1: After reset, `bus_word` is 16'hC300: bits 8, 9, 14 and 15 are high, and every other bit is low. `data_oe`, `ready` and `cfg_wr` are low.
- R2: The low-address phase drives `req_addr[7:0]` on bits 7:0 with bit 10 high for exactly SETUP_CYC cycles. Bit 10 then falls while the byte is still held for one more cycle.
- R3: The high-address phase drives `req_addr[15:8]` on bits 7:0 with bit 11 high for exactly SETUP_CYC cycles. Bit 11 then falls with the byte held for one more cycle. Bits 10 and 11 are never high together.
- R4: On a write (`req_rnw`=0), `req_wdata` is driven on bits 7:0 with `data_oe` high while the strobe is low. On a read, `data_oe` is low before and during the strobe.
- R5: Target 0 pulls bit 8 low and target 1 pulls bit 9 low. The two are never low together, and a strobe is only low while one select is low.
- R6: A read asserts bit 14 low and a write asserts bit 15 low. The acknowledge input `bus_ack_n` is active low and passes through two synchronizing flops.
- R7: When a synchronized acknowledge ends the wait, `rdata` holds `bus_data_in` as sampled in that cycle and `timed_out` is 0. If no acknowledge arrives, the strobe stays low for exactly TIMEOUT_CYC cycles. `timed_out` is then 1 and `rdata` still holds the sampled byte.
- R8: `ready` is high for exactly one cycle per request. A request made while a transfer is in progress, or in the `ready` cycle, is ignored.
- R9: `cfg_wr` pulses once, with `cfg_space` = 2'b01 for control space and 2'b00 for attribute memory, only when `req_ctrl` differs from the last space used. Attribute memory is the space assumed after reset.
- R10: A request whose `req_slot` is not zero gives `ready` with `rejected`=1 in the next cycle, with no select, strobe or `cfg_wr` activity.
- R11: In the cycle after the wait ends, bits 8, 9, 14 and 15 are high again and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle transfer request |
| req_slot | input | SLOT_W | Slot index; only 0 is served |
| req_addr | input | 16 | Module address |
| req_wdata | input | 8 | Byte to write |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_ctrl | input | 1 | 1 = control space, 0 = attribute memory |
| req_target | input | 1 | Chip select choice |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with ready |
| timed_out | output | 1 | Wait ended without acknowledge |
| rejected | output | 1 | Request refused for a nonzero slot |
| cfg_wr | output | 1 | Space field update strobe |
| cfg_space | output | 2 | Space field value for the update |
| bus_word | output | 16 | Bus control and data lines |
| data_oe | output | 1 | Drive enable for bits 7:0 |
| bus_data_in | input | 8 | Data lines as read from the bus |
| bus_ack_n | input | 1 | Active-low acknowledge from the module |

## Verification
The bench sweeps every combination of target, direction and space over several addresses and acknowledge delays, with a bus model that latches the address from the strobes. This catches swapped address bytes, which would latch the wrong byte. It also catches a wrong chip select, which would wake the other module, and data lines left driven during a read, which would make the bench flag a drive conflict. Repeated and alternating space choices check that the configuration update fires only on a change. A design that rewrote the field on every access would show extra strobes. Timed-out reads and writes check the exact strobe length and that the sampled byte still comes back. Nonzero slots and requests made mid-transfer check that nothing reaches the bus or produces an extra `ready`.

// File: rtl/cam_bus_pkg.sv
package cam_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPACE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_DATA,
        ST_SELECT,
        ST_STROBE
    } cam_state_e;

    // positions on the bus word; the module side decodes these
    localparam int BIT_CS0 = 8;
    localparam int BIT_CS1 = 9;
    localparam int BIT_ALO = 10;
    localparam int BIT_AHI = 11;
    localparam int BIT_RD  = 14;
    localparam int BIT_WR  = 15;

    localparam logic [1:0] SPACE_ATTR = 2'b00;
    localparam logic [1:0] SPACE_CTRL = 2'b01;

endpackage

// File: rtl/cam_ack_sync.sv
module cam_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cam_phase_cnt.sv
module cam_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end
endmodule

// File: rtl/cam_bus_master.sv
module cam_bus_master
    import cam_bus_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 50000,
    parameter int SLOT_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [15:0]       req_addr,
    input  logic [7:0]        req_wdata,
    input  logic              req_rnw,
    input  logic              req_ctrl,
    input  logic              req_target,
    output logic              ready,
    output logic [7:0]        rdata,
    output logic              timed_out,
    output logic              rejected,
    output logic              cfg_wr,
    output logic [1:0]        cfg_space,
    output logic [15:0]       bus_word,
    output logic              data_oe,
    input  logic [7:0]        bus_data_in,
    input  logic              bus_ack_n
);
    localparam int CW = $clog2(TIMEOUT_CYC + SETUP_CYC + 2) + 1;
    localparam logic [CW-1:0] L_SETUP    = CW'(SETUP_CYC);
    localparam logic [CW-1:0] L_SETUP_M1 = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] L_TO_M1    = CW'(TIMEOUT_CYC - 1);

    cam_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic          ack_s;
    logic          wait_end;
    logic          accept;
    logic [15:0]   addr_q;
    logic [7:0]    wdata_q;
    logic          rnw_q, tgt_q, ctrl_q, last_ctrl;

    cam_ack_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(bus_ack_n), .sync_out(ack_s)
    );

    cam_phase_cnt #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr((nxt != state) || (state == ST_IDLE)),
        .count(cnt)
    );

    assign accept   = req && !ready && (state == ST_IDLE);
    assign wait_end = !ack_s || (cnt == L_TO_M1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (accept && (req_slot == '0))
                            nxt = (req_ctrl != last_ctrl) ? ST_SPACE : ST_ADDR_LO;
            ST_SPACE:   nxt = ST_ADDR_LO;
            ST_ADDR_LO: if (cnt == L_SETUP) nxt = ST_ADDR_HI;
            ST_ADDR_HI: if (cnt == L_SETUP) nxt = ST_DATA;
            ST_DATA:    if (cnt == L_SETUP_M1) nxt = ST_SELECT;
            ST_SELECT:  if (cnt == L_SETUP_M1) nxt = ST_STROBE;
            ST_STROBE:  if (wait_end) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // request capture and completion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            rnw_q     <= 1'b0;
            tgt_q     <= 1'b0;
            ctrl_q    <= 1'b0;
            last_ctrl <= 1'b0;
            ready     <= 1'b0;
            rdata     <= '0;
            timed_out <= 1'b0;
            rejected  <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (accept) begin
                if (req_slot != '0) begin
                    ready     <= 1'b1;
                    rejected  <= 1'b1;
                    timed_out <= 1'b0;
                end else begin
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    rnw_q   <= req_rnw;
                    tgt_q   <= req_target;
                    ctrl_q  <= req_ctrl;
                end
            end
            if (state == ST_SPACE) last_ctrl <= ctrl_q;
            if ((state == ST_STROBE) && wait_end) begin
                ready     <= 1'b1;
                rejected  <= 1'b0;
                timed_out <= ack_s;
                rdata     <= bus_data_in;
            end
        end
    end

    // outputs
    always_comb begin
        bus_word         = '0;
        bus_word[BIT_CS0] = 1'b1;
        bus_word[BIT_CS1] = 1'b1;
        bus_word[BIT_RD]  = 1'b1;
        bus_word[BIT_WR]  = 1'b1;
        data_oe   = 1'b0;
        cfg_wr    = (state == ST_SPACE);
        cfg_space = ctrl_q ? SPACE_CTRL : SPACE_ATTR;
        unique case (state)
            ST_ADDR_LO: begin
                bus_word[7:0]    = addr_q[7:0];
                bus_word[BIT_ALO] = (cnt < L_SETUP);
                data_oe          = 1'b1;
            end
            ST_ADDR_HI: begin
                bus_word[7:0]    = addr_q[15:8];
                bus_word[BIT_AHI] = (cnt < L_SETUP);
                data_oe          = 1'b1;
            end
            ST_DATA, ST_SELECT, ST_STROBE: begin
                bus_word[7:0] = rnw_q ? 8'h00 : wdata_q;
                data_oe       = !rnw_q;
                if (state != ST_DATA) begin
                    if (tgt_q) bus_word[BIT_CS1] = 1'b0;
                    else       bus_word[BIT_CS0] = 1'b0;
                end
                if (state == ST_STROBE) begin
                    if (rnw_q) bus_word[BIT_RD] = 1'b0;
                    else       bus_word[BIT_WR] = 1'b0;
                end
            end
            default: ;
        endcase
    end

    AST_ADDR_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_word[BIT_ALO] && bus_word[BIT_AHI])); // R3
    AST_RD_RELEASES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_word[BIT_RD] |-> !data_oe); // R4
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{bus_word[BIT_CS1], bus_word[BIT_CS0]})); // R5
    AST_STROBE_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_word[BIT_RD] || !bus_word[BIT_WR]) |-> !(bus_word[BIT_CS0] && bus_word[BIT_CS1])); // R5
    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rejected) |-> $past(!bus_word[BIT_RD] || !bus_word[BIT_WR])); // R7
    AST_TIMEOUT_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out && ready |-> !rejected); // R7
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R8
    AST_CFG_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (ctrl_q != last_ctrl)); // R9
    AST_REJECT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && rejected) |-> $past(state == ST_IDLE) && bus_word[BIT_CS0] && bus_word[BIT_CS1]); // R10
    AST_IDLE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !rejected) |-> (bus_word[BIT_RD] && bus_word[BIT_WR] && bus_word[BIT_CS0] && bus_word[BIT_CS1])); // R11
endmodule

// File: tb/cam_bus_master_test.sv
`timescale 1ns/1ps
module cam_bus_master_test;
    localparam int SETUP = 2;
    localparam int TO    = 24;
    localparam int NEVER = 999;

    logic clk = 0, rst_n = 0;
    logic req = 0;
    logic [1:0] req_slot = 0;
    logic [15:0] req_addr = 0;
    logic [7:0] req_wdata = 0;
    logic req_rnw = 0, req_ctrl = 0, req_target = 0;
    logic ready, timed_out, rejected, cfg_wr, data_oe;
    logic [7:0] rdata;
    logic [1:0] cfg_space;
    logic [15:0] bus_word;
    logic [7:0] bus_data_in;
    logic bus_ack_n;

    int n_chk = 0, n_fail = 0;

    cam_bus_master #(.SETUP_CYC(SETUP), .TIMEOUT_CYC(TO), .SLOT_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_slot(req_slot), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_rnw(req_rnw), .req_ctrl(req_ctrl), .req_target(req_target),
        .ready(ready), .rdata(rdata), .timed_out(timed_out), .rejected(rejected),
        .cfg_wr(cfg_wr), .cfg_space(cfg_space), .bus_word(bus_word), .data_oe(data_oe),
        .bus_data_in(bus_data_in), .bus_ack_n(bus_ack_n)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_val(input logic [15:0] a, input logic t);
        return a[7:0] ^ a[15:8] ^ (t ? 8'hA5 : 8'h3C);
    endfunction

    // bus model
    int ack_dly = 0;
    logic mon_clr = 0;
    logic [7:0] s_lo, s_hi, s_wd;
    logic [1:0] s_cs;
    int scnt, s_strobe_n, s_alo_n, s_ahi_n, cfg_n, s_sel_seen, s_oe_err;
    logic [1:0] s_cfg;
    logic ack_r;

    assign bus_ack_n = ack_r;
    assign bus_data_in = !bus_word[14] ? mem_val({s_hi, s_lo}, bus_word[8]) : 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1; scnt <= 0; cfg_n <= 0; s_cfg <= 0;
            s_lo <= 0; s_hi <= 0; s_wd <= 0; s_cs <= 2'b11;
            s_strobe_n <= 0; s_alo_n <= 0; s_ahi_n <= 0; s_sel_seen <= 0; s_oe_err <= 0;
        end else begin
            if (mon_clr) begin
                s_strobe_n <= 0; s_alo_n <= 0; s_ahi_n <= 0; s_sel_seen <= 0; s_oe_err <= 0;
                s_cs <= 2'b11;
            end else begin
                if (bus_word[10]) begin s_lo <= bus_word[7:0]; s_alo_n <= s_alo_n + 1; end
                if (bus_word[11]) begin s_hi <= bus_word[7:0]; s_ahi_n <= s_ahi_n + 1; end
                if (bus_word[9:8] != 2'b11) s_sel_seen <= s_sel_seen + 1;
                if (!bus_word[14] || !bus_word[15]) begin
                    s_strobe_n <= s_strobe_n + 1;
                    s_cs <= bus_word[9:8];
                    if (!bus_word[15]) begin
                        s_wd <= bus_word[7:0];
                        if (!data_oe) s_oe_err <= s_oe_err + 1;
                    end
                    if (!bus_word[14] && data_oe) s_oe_err <= s_oe_err + 1;
                end
            end
            if (!bus_word[14] || !bus_word[15]) begin
                scnt  <= scnt + 1;
                ack_r <= !(scnt >= ack_dly);
            end else begin
                scnt  <= 0;
                ack_r <= 1;
            end
            if (cfg_wr) begin cfg_n <= cfg_n + 1; s_cfg <= cfg_space; end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [7:0] o_rd;
    logic o_to, o_rej;
    int  o_cfg_delta;

    task automatic xfer(input logic [1:0] slot, input logic [15:0] a, input logic [7:0] wd,
                        input logic rnw, input logic ctrl, input logic tgt, input int dly);
        int cfg0;
        int waited;
        ack_dly = dly;
        @(negedge clk);
        mon_clr = 1;
        @(negedge clk);
        mon_clr = 0;
        cfg0 = cfg_n;
        req = 1; req_slot = slot; req_addr = a; req_wdata = wd;
        req_rnw = rnw; req_ctrl = ctrl; req_target = tgt;
        @(negedge clk);
        req = 0;
        if (slot == 0 && !ready) begin
            // spurious request while busy, must be ignored (R8)
            @(negedge clk);
            req = 1; req_slot = 2'd1; req_addr = ~a;
            @(negedge clk);
            req = 0; req_slot = 0;
        end
        waited = 0;
        while (!ready && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        chk(ready, "R8 ready seen", ready, 1);
        o_rd = rdata; o_to = timed_out; o_rej = rejected;
        chk(bus_word[15:14] == 2'b11 && bus_word[9:8] == 2'b11 || o_rej,
            "R11 bus idle with ready", bus_word, 16'hC300);
        @(negedge clk);
        chk(!ready, "R8 ready one cycle", ready, 0);
        o_cfg_delta = cfg_n - cfg0;
    endtask

    bit exp_last = 0;

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_word == 16'hC300, "R1 reset bus word", bus_word, 16'hC300);
        chk(!ready && !data_oe && !cfg_wr, "R1 reset outputs", {ready, data_oe, cfg_wr}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int ti = 0; ti < 2; ti++)
          for (int ri = 0; ri < 2; ri++)
            for (int ci = 0; ci < 2; ci++)
              for (int ai = 0; ai < 4; ai++) begin
                  logic [15:0] a;
                  logic [7:0] wd;
                  a  = 16'h1234 * (ai + 1) + 16'h0F0 * ti + 16'h301 * ci;
                  wd = 8'h5A ^ a[7:0] ^ 8'(ri);
                  xfer(2'd0, a, wd, ri[0], ci[0], ti[0], ai);
                  chk(!o_rej, "R10 slot0 accepted", o_rej, 0);
                  chk(!o_to, "R7 no timeout on ack", o_to, 0);
                  chk(s_lo == a[7:0], "R2 low address", s_lo, a[7:0]);
                  chk(s_hi == a[15:8], "R3 high address", s_hi, a[15:8]);
                  chk(s_alo_n == SETUP, "R2 low strobe length", s_alo_n, SETUP);
                  chk(s_ahi_n == SETUP, "R3 high strobe length", s_ahi_n, SETUP);
                  chk(s_cs == (ti ? 2'b01 : 2'b10), "R5 chip select", s_cs, ti ? 1 : 2);
                  chk(s_oe_err == 0, "R4 data direction", s_oe_err, 0);
                  if (ri) chk(o_rd == mem_val(a, ti[0]), "R7 read byte", o_rd, mem_val(a, ti[0]));
                  else    chk(s_wd == wd, "R6 write byte", s_wd, wd);
                  chk(o_cfg_delta == ((ci[0] != exp_last) ? 1 : 0), "R9 space update count",
                      o_cfg_delta, (ci[0] != exp_last) ? 1 : 0);
                  if (ci[0] != exp_last)
                      chk(s_cfg == (ci ? 2'b01 : 2'b00), "R9 space value", s_cfg, ci ? 1 : 0);
                  exp_last = ci[0];
              end

        // timeouts: read and write
        for (int ri = 0; ri < 2; ri++) begin
            xfer(2'd0, 16'hBEEF, 8'h77, ri[0], exp_last, 1'b1, NEVER);
            chk(o_to, "R7 timeout flag", o_to, 1);
            chk(s_strobe_n == TO, "R7 timeout strobe length", s_strobe_n, TO);
            if (ri) chk(o_rd == mem_val(16'hBEEF, 1'b1), "R7 timed-out read byte",
                        o_rd, mem_val(16'hBEEF, 1'b1));
            chk(s_lo == 8'hEF && s_hi == 8'hBE, "R6 address after timeout", {s_hi, s_lo}, 16'hBEEF);
        end

        // nonzero slots are refused
        for (int si = 1; si < 4; si++) begin
            xfer(2'(si), 16'h0042, 8'h11, 1'b0, ~exp_last, 1'b0, 0);
            chk(o_rej, "R10 reject flag", o_rej, 1);
            chk(s_sel_seen == 0 && s_strobe_n == 0, "R10 no bus activity",
                s_sel_seen + s_strobe_n, 0);
            chk(o_cfg_delta == 0, "R10 no space update", o_cfg_delta, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule